// File: doc/BRIEF.md
# Interrupt Synchronizer and Edge Detector

This block accepts a vector of interrupt request lines, which may be raw or already filtered, and presents them in an interrupt clock domain. That clock is synchronous to the bus clock, but it keeps running while the bus clock is gated off, so interrupts are still seen when the bus is idle. Software sets four controls for each line: an enable, a choice between level and edge sensitivity, an edge polarity, and, for level lines only, whether the level is passed through a synchronizer.

An edge-sensitive line always goes through the synchronizer before detection. Each qualifying edge produces a pulse that lasts exactly one interrupt clock cycle. A level-sensitive line is passed on either straight through or after synchronization. The block also drives a clock-request output. An external clock generator uses it to keep the interrupt clock running whenever some enabled line needs it.

Each line has a lane with a path selector, which is an enumerated state decoded from that line's controls. The states are `PATH_OFF`, `PATH_LVL_RAW`, `PATH_LVL_SYNC` and `PATH_EDGE`. Any control write can move a lane from one state to any other. The transitions are: disable (any state → `PATH_OFF`); choose edge (→ `PATH_EDGE`); choose a synchronized level (→ `PATH_LVL_SYNC`); choose a raw level (→ `PATH_LVL_RAW`). The synchronizer flops keep tracking the input in every state. As a result, a change of state never brings stale history into the output.

Top module: `intsync_edge_det`

## Requirements
- R1: While reset is asserted (active-low, asynchronous), all synchronizer flops clear to zero. With all inputs low, `irq_out` and `clk_req` read zero after reset.
- R2: In edge mode with `cfg_pol`=1, a rising input edge produces `irq_out`=1 from the second rising clock edge after the input changes. The output is low after the first of those clock edges.
- R3: In edge mode with `cfg_pol`=0, a falling input edge produces the pulse with the same two-clock latency. A rising edge produces none.
- R4: An edge pulse lasts exactly one clock cycle, even while the input holds its new value.
- R5: In level mode (`cfg_edge`=0) with `cfg_lvl_sync`=0, `irq_out` follows `irq_in` in the same cycle, with no clock involved.
- R6: In level mode with `cfg_lvl_sync`=1, `irq_out` equals the input as sampled two rising clock edges earlier.
- R7: A line with `cfg_en`=0 keeps its `irq_out` bit low in every mode. Enabling an edge-mode line while its input holds steady produces no pulse.
- R8: `clk_req` is 1 exactly when at least one line has `cfg_en`=1 and is either edge-sensitive or level-sensitive with `cfg_lvl_sync`=1.
- R9: Each line's mode and output are independent of every other line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_intr | input | 1 | Interrupt clock, synchronous to the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | N | Interrupt request lines, raw or filtered |
| cfg_en | input | N | Per-line enable (1 = enabled) |
| cfg_edge | input | N | Per-line sensitivity (1 = edge, 0 = level) |
| cfg_pol | input | N | Per-line edge polarity (1 = rising, 0 = falling) |
| cfg_lvl_sync | input | N | Per-line level synchronizer select (1 = synchronized) |
| irq_out | output | N | Edge pulses or level values, per line |
| clk_req | output | 1 | Request to keep the interrupt clock running |

## Verification
The bench measures the exact cycle of the edge pulse and its width. A detector that looked one stage too early would pulse one cycle early. A detector that compared the wrong stages would hold the output high for as long as the input stays high.

Wrong-polarity edges must stay silent. Re-enabling a line whose input is already high must not produce a phantom pulse, which would happen if disabling also froze or cleared the synchronizer.

The level paths are checked for zero latency on the raw path and for two-cycle latency on the synchronized path. The clock request is checked for each mode combination, so a design that requests the clock for a raw level, or ignores the enable, is caught. A mixed-mode case confirms that lanes do not leak into one another.

// File: rtl/intsync_pkg.sv
package intsync_pkg;

    // Per-lane path selection decoded from the software controls
    typedef enum logic [1:0] {
        PATH_OFF      = 2'd0,
        PATH_LVL_RAW  = 2'd1,
        PATH_LVL_SYNC = 2'd2,
        PATH_EDGE     = 2'd3
    } path_sel_e;

    function automatic path_sel_e decode_path(input logic en, input logic edge_mode,
                                              input logic lvl_sync);
        if (!en)
            return PATH_OFF;
        else if (edge_mode)
            return PATH_EDGE;
        else if (lvl_sync)
            return PATH_LVL_SYNC;
        else
            return PATH_LVL_RAW;
    endfunction

endpackage

// File: rtl/intsync_sync_chain.sv
// Shift chain of asynchronously reset flops; q[0] is the first stage.
module intsync_sync_chain #(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             d,
    output logic [DEPTH-1:0] q
);

    logic [DEPTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stage_q[0] <= 1'b0;
        else
            stage_q[0] <= d;
    end

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stage_q[s] <= 1'b0;
            else
                stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q;

endmodule

// File: rtl/intsync_lane.sv
// One interrupt line: synchronizer, delayed stage, path select and output.
module intsync_lane
    import intsync_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_raw,
    input  logic en,
    input  logic edge_mode,
    input  logic rise_pol,
    input  logic lvl_sync,
    output logic irq_o,
    output logic need_clk
);

    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;
    logic             synced;
    logic             delayed;
    logic             rise_seen;
    logic             fall_seen;
    path_sel_e        path;

    intsync_sync_chain #(.DEPTH(CHAIN)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_raw),
        .q     (chain_q)
    );

    assign synced    = chain_q[SYNC_STAGES-1];
    assign delayed   = chain_q[SYNC_STAGES];
    assign rise_seen = synced & ~delayed;
    assign fall_seen = ~synced & delayed;

    // State decode: which path drives this lane
    always_comb begin
        path = decode_path(en, edge_mode, lvl_sync);
    end

    // Output process
    always_comb begin
        irq_o    = 1'b0;
        need_clk = 1'b0;
        unique case (path)
            PATH_OFF: begin
                irq_o    = 1'b0;
                need_clk = 1'b0;
            end
            PATH_LVL_RAW: begin
                irq_o    = irq_raw;
                need_clk = 1'b0;
            end
            PATH_LVL_SYNC: begin
                irq_o    = synced;
                need_clk = 1'b1;
            end
            PATH_EDGE: begin
                irq_o    = rise_pol ? rise_seen : fall_seen;
                need_clk = 1'b1;
            end
            default: begin
                irq_o    = 1'b0;
                need_clk = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/intsync_clkreq.sv
// Clock request: any lane that needs the interrupt clock raises it.
module intsync_clkreq #(
    parameter int N = 8
) (
    input  logic [N-1:0] need,
    output logic         req
);

    always_comb begin
        req = 1'b0;
        for (int i = 0; i < N; i++)
            req = req | need[i];
    end

endmodule

// File: rtl/intsync_edge_det.sv
module intsync_edge_det #(
    parameter int N           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk_intr,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] cfg_en,
    input  logic [N-1:0] cfg_edge,
    input  logic [N-1:0] cfg_pol,
    input  logic [N-1:0] cfg_lvl_sync,
    output logic [N-1:0] irq_out,
    output logic         clk_req
);

    logic [N-1:0] lane_need;

    for (genvar i = 0; i < N; i++) begin : g_lane
        intsync_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
            .clk       (clk_intr),
            .rst_n     (rst_n),
            .irq_raw   (irq_in[i]),
            .en        (cfg_en[i]),
            .edge_mode (cfg_edge[i]),
            .rise_pol  (cfg_pol[i]),
            .lvl_sync  (cfg_lvl_sync[i]),
            .irq_o     (irq_out[i]),
            .need_clk  (lane_need[i])
        );
    end

    intsync_clkreq #(.N(N)) u_clkreq (
        .need (lane_need),
        .req  (clk_req)
    );

endmodule

// File: rtl/intsync_edge_det_chk.sv
module intsync_edge_det_chk #(
    parameter int N           = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic         clk_intr,
    input logic         rst_n,
    input logic [N-1:0] irq_in,
    input logic [N-1:0] cfg_en,
    input logic [N-1:0] cfg_edge,
    input logic [N-1:0] cfg_pol,
    input logic [N-1:0] cfg_lvl_sync,
    input logic [N-1:0] irq_out,
    input logic         clk_req
);

    // Cycles since reset release, saturating, so that $past never reaches before reset
    logic [1:0] age;
    always_ff @(posedge clk_intr or negedge rst_n) begin
        if (!rst_n)
            age <= 2'd0;
        else if (age != 2'd3)
            age <= age + 2'd1;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R7
        off_low_chk: assert property (@(posedge clk_intr) disable iff (!rst_n)
            !cfg_en[i] |-> !irq_out[i]);

        // R4
        one_cycle_pulse_chk: assert property (@(posedge clk_intr) disable iff (!rst_n)
            (irq_out[i] && cfg_en[i] && cfg_edge[i])
            |=> !(irq_out[i] && cfg_en[i] && cfg_edge[i] && $stable(cfg_pol[i])));

        // R5
        raw_level_chk: assert property (@(posedge clk_intr) disable iff (!rst_n)
            (cfg_en[i] && !cfg_edge[i] && !cfg_lvl_sync[i]) |-> (irq_out[i] == irq_in[i]));

        // R6
        sync_level_chk: assert property (@(posedge clk_intr) disable iff (!rst_n)
            (age == 2'd3 && cfg_en[i] && !cfg_edge[i] && cfg_lvl_sync[i])
            |-> (irq_out[i] == $past(irq_in[i], 2)));

        // R8
        edge_req_chk: assert property (@(posedge clk_intr) disable iff (!rst_n)
            (cfg_en[i] && (cfg_edge[i] || cfg_lvl_sync[i])) |-> clk_req);
    end

    // R8
    req_cause_chk: assert property (@(posedge clk_intr) disable iff (!rst_n)
        clk_req |-> ((cfg_en & (cfg_edge | cfg_lvl_sync)) != '0));

endmodule

bind intsync_edge_det intsync_edge_det_chk #(.N(N), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/tb_intsync_edge_det.sv
module tb_intsync_edge_det;

    localparam int N = 8;

    logic         clk_intr = 1'b0;
    logic         rst_n;
    logic [N-1:0] irq_in, cfg_en, cfg_edge, cfg_pol, cfg_lvl_sync;
    logic [N-1:0] irq_out;
    logic         clk_req;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk_intr = ~clk_intr;   // 125 MHz

    intsync_edge_det #(.N(N)) dut (
        .clk_intr     (clk_intr),
        .rst_n        (rst_n),
        .irq_in       (irq_in),
        .cfg_en       (cfg_en),
        .cfg_edge     (cfg_edge),
        .cfg_pol      (cfg_pol),
        .cfg_lvl_sync (cfg_lvl_sync),
        .irq_out      (irq_out),
        .clk_req      (clk_req)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic settle();
        irq_in = '0;
        repeat (4) @(negedge clk_intr);
    endtask

    task automatic t_reset();
        irq_in = '0; cfg_en = '0; cfg_edge = '0; cfg_pol = '0; cfg_lvl_sync = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk_intr);
        rst_n = 1'b1;
        @(negedge clk_intr);
        chk("R1 out after reset", irq_out, '0);
        chk1("R1 clk_req after reset", clk_req, 1'b0);
        cfg_en = 8'h01; cfg_edge = 8'h01; cfg_pol = 8'h01;
        repeat (2) @(negedge clk_intr);
        chk("R1 edge lane quiet with low input", irq_out, '0);
    endtask

    task automatic t_rise();
        cfg_en = 8'h01; cfg_edge = 8'h01; cfg_pol = 8'h01; cfg_lvl_sync = '0;
        settle();
        irq_in = 8'h01;
        @(negedge clk_intr); chk("R2 no pulse after one clock", irq_out, 8'h00);
        @(negedge clk_intr); chk("R2 rising pulse on second clock", irq_out, 8'h01);
        @(negedge clk_intr); chk("R4 pulse ends after one cycle", irq_out, 8'h00);
        @(negedge clk_intr); chk("R4 held input gives no repeat", irq_out, 8'h00);
        irq_in = 8'h00;
        repeat (3) begin
            @(negedge clk_intr); chk("R2 falling edge ignored in rising mode", irq_out, 8'h00);
        end
    endtask

    task automatic t_fall();
        cfg_en = 8'h01; cfg_edge = 8'h01; cfg_pol = 8'h00; cfg_lvl_sync = '0;
        settle();
        irq_in = 8'h01;
        repeat (3) begin
            @(negedge clk_intr); chk("R3 rising edge ignored in falling mode", irq_out, 8'h00);
        end
        irq_in = 8'h00;
        @(negedge clk_intr); chk("R3 no pulse after one clock", irq_out, 8'h00);
        @(negedge clk_intr); chk("R3 falling pulse on second clock", irq_out, 8'h01);
        @(negedge clk_intr); chk("R4 falling pulse one cycle", irq_out, 8'h00);
    endtask

    task automatic t_level_raw();
        cfg_en = 8'h01; cfg_edge = 8'h00; cfg_pol = 8'h00; cfg_lvl_sync = 8'h00;
        settle();
        irq_in = 8'h01; #1;
        chk("R5 raw level follows at once", irq_out, 8'h01);
        chk1("R8 raw level does not request clock", clk_req, 1'b0);
        irq_in = 8'h00; #1;
        chk("R5 raw level drops at once", irq_out, 8'h00);
    endtask

    task automatic t_level_sync();
        cfg_en = 8'h01; cfg_edge = 8'h00; cfg_pol = 8'h00; cfg_lvl_sync = 8'h01;
        settle();
        irq_in = 8'h01;
        @(negedge clk_intr); chk("R6 sync level after one clock", irq_out, 8'h00);
        @(negedge clk_intr); chk("R6 sync level after two clocks", irq_out, 8'h01);
        @(negedge clk_intr); chk("R6 sync level stays high", irq_out, 8'h01);
        irq_in = 8'h00;
        @(negedge clk_intr); chk("R6 sync level holds one clock", irq_out, 8'h01);
        @(negedge clk_intr); chk("R6 sync level drops", irq_out, 8'h00);
    endtask

    task automatic t_enable();
        cfg_en = 8'h00; cfg_edge = 8'h01; cfg_pol = 8'h01; cfg_lvl_sync = 8'h00;
        settle();
        irq_in = 8'h01;
        repeat (3) begin
            @(negedge clk_intr); chk("R7 disabled edge lane stays low", irq_out, 8'h00);
        end
        cfg_en = 8'h01;
        repeat (2) begin
            @(negedge clk_intr); chk("R7 enabling with held input gives no pulse", irq_out, 8'h00);
        end
        cfg_en = 8'h00; cfg_edge = 8'h00; #1;
        chk("R7 disabled raw level stays low", irq_out, 8'h00);
    endtask

    task automatic t_clkreq();
        irq_in = '0;
        cfg_en = 8'h00; cfg_edge = 8'hFF; cfg_lvl_sync = 8'hFF; #1;
        chk1("R8 all disabled", clk_req, 1'b0);
        cfg_en = 8'h10; cfg_edge = 8'h10; cfg_lvl_sync = 8'h00; #1;
        chk1("R8 one edge lane", clk_req, 1'b1);
        cfg_en = 8'h10; cfg_edge = 8'h00; cfg_lvl_sync = 8'h10; #1;
        chk1("R8 one sync level lane", clk_req, 1'b1);
        cfg_en = 8'h10; cfg_edge = 8'h00; cfg_lvl_sync = 8'h00; #1;
        chk1("R8 raw level only", clk_req, 1'b0);
        cfg_en = 8'h80; cfg_edge = 8'h01; cfg_lvl_sync = 8'h02; #1;
        chk1("R8 needy lanes disabled", clk_req, 1'b0);
        @(negedge clk_intr);
    endtask

    task automatic t_lanes();
        // lane0 rising edge, lane1 raw level, lane2 disabled, lane3 falling edge
        cfg_en = 8'h0B; cfg_edge = 8'h09; cfg_pol = 8'h01; cfg_lvl_sync = 8'h00;
        settle();
        irq_in = 8'h0F; #1;
        chk("R9 lanes at once", irq_out, 8'h02);
        @(negedge clk_intr); chk("R9 lanes after one clock", irq_out, 8'h02);
        @(negedge clk_intr); chk("R9 lanes after two clocks", irq_out, 8'h03);
        irq_in = 8'h00;
        @(negedge clk_intr); chk("R9 lanes after release", irq_out, 8'h00);
        @(negedge clk_intr); chk("R9 falling lane fires alone", irq_out, 8'h08);
        @(negedge clk_intr); chk("R9 lanes quiet", irq_out, 8'h00);
    endtask

    initial begin
        t_reset();
        t_rise();
        t_fall();
        t_level_raw();
        t_level_sync();
        t_enable();
        t_clkreq();
        t_lanes();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_intr);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule